// File: doc/BRIEF.md
# Masked Interrupt Status Controller

This block gathers up to 27 single-cycle or level event lines into one sticky status word. Each bit stays set until software writes a 1 to that bit position in the status register. A mask register picks which latched bits may raise an interrupt. A one-bit global gate then decides whether the single level interrupt line may be driven at all. The block also gives the position of the lowest-numbered bit that is both latched and unmasked, so that a dispatcher can service sources in ascending order without scanning the word.

Only eleven source positions are implemented. Positions 0 to 7 and 9 carry descriptor-engine events: in and out completion, OK, error and end of list, plus the in-direction out-of-descriptors event. Positions 25 and 26 carry the external device interrupt and the bus abort event. All other positions are absent from both the status and the mask registers. Software reaches the three registers through a plain single-cycle read/write port. Reads are combinational, and a write takes effect at the clock edge that samples it.

Top module: `irq_status_ctrl`

## Requirements
- R1: While `rst_n` is low and after its release, the status, mask and gate registers are 0, `irq_o` is 0 and `irq_idx_o` is 0.
- R2: An event input that is high at a clock edge sets its status bit at that edge. The bit then stays set, and reads back at offset 0x500, until it is cleared.
- R3: A write to offset 0x500 clears every status bit whose write-data bit is 1 and leaves the bits written 0 unchanged.
- R4: When an event arrives at the same edge as a clearing write to its bit, the bit is set after that edge.
- R5: Offset 0x504 holds the mask. It is written and read back in place, bit n masking source n, and only the implemented positions are stored.
- R6: Offset 0x508 holds the global gate in bit 0. A write of bit 0 stores it, and bits 31:1 read as 0.
- R7: `irq_o` is 1 exactly when the gate is 1 and the status AND mask word is nonzero.
- R8: `pend_any_o` is 1 when status AND mask is nonzero. `irq_idx_o` then gives the lowest set position of that word, and it is 0 when the word is zero. Neither output depends on the gate.
- R9: Positions 8, 10 to 24 and 27 to 31 are not implemented. Events on them never set a status bit, writes to them are dropped, and they read as 0.
- R10: `bus_rdata_o` is 0 whenever no read is selected (`bus_sel_i` low or `bus_wr_i` high) and for reads at any offset other than 0x500, 0x504 and 0x508. Writes to other offsets change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 27 | Event lines, bit n feeds status bit n |
| bus_sel_i | input | 1 | Register access select |
| bus_wr_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | 12 | Register byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Combinational read data |
| irq_o | output | 1 | Level interrupt request |
| irq_idx_o | output | 5 | Lowest pending unmasked source position |
| pend_any_o | output | 1 | Some unmasked source is latched |

## Verification
The assertions take for granted that `rst_n` is low from time zero, so that their one-cycle look-backs never see values from before reset. They also take for granted that event lines hold a known value at every edge, because a set-or-clear check on an unknown bit means nothing. The stimulus holds events at 0 during reset and drives every input from one procedural thread at the falling edge. It mixes random sparse event words, including the unimplemented positions, with accesses to the three offsets and to unmapped ones, so every input stays defined at each sampled edge.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  localparam int unsigned DEF_NSRC   = 27;
  localparam int unsigned DEF_DATA_W = 32;
  localparam int unsigned DEF_ADDR_W = 12;

  // Implemented source positions: 0..7, 9, 25, 26
  localparam logic [DEF_NSRC-1:0] DEF_LEGAL = 27'h600_02FF;

  localparam logic [DEF_ADDR_W-1:0] OFF_STAT = 12'h500;
  localparam logic [DEF_ADDR_W-1:0] OFF_MASK = 12'h504;
  localparam logic [DEF_ADDR_W-1:0] OFF_GATE = 12'h508;

  typedef struct packed {
    logic stat;
    logic mask;
    logic gate;
  } reg_hit_t;

  // Next state of the sticky word: clear first, then events win.
  function automatic logic [DEF_NSRC-1:0] sticky_next(
    input logic [DEF_NSRC-1:0] cur,
    input logic [DEF_NSRC-1:0] clr,
    input logic [DEF_NSRC-1:0] evt,
    input logic [DEF_NSRC-1:0] legal
  );
    return ((cur & ~clr) | evt) & legal;
  endfunction

endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
  import irq_agg_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W
) (
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output reg_hit_t          wr_hit_o,
  output reg_hit_t          rd_hit_o
);

  reg_hit_t at;

  always_comb begin
    at.stat = (addr_i == ADDR_W'(OFF_STAT));
    at.mask = (addr_i == ADDR_W'(OFF_MASK));
    at.gate = (addr_i == ADDR_W'(OFF_GATE));
  end

  always_comb begin
    wr_hit_o = (sel_i &&  wr_i) ? at : '0;
    rd_hit_o = (sel_i && !wr_i) ? at : '0;
  end

endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
  import irq_agg_pkg::*;
#(
  parameter int unsigned         NSRC  = DEF_NSRC,
  parameter logic [NSRC-1:0]     LEGAL = DEF_LEGAL
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] stat_o
);

  logic [NSRC-1:0] stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= ((stat_q & ~clr_i) | evt_i) & LEGAL;
  end

  assign stat_o = stat_q;

endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_agg_pkg::*;
#(
  parameter int unsigned     NSRC  = DEF_NSRC,
  parameter logic [NSRC-1:0] LEGAL = DEF_LEGAL
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_mask_i,
  input  logic            wr_gate_i,
  input  logic [NSRC-1:0] wdata_i,
  output logic [NSRC-1:0] mask_o,
  output logic            gate_o
);

  logic [NSRC-1:0] mask_q;
  logic            gate_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      gate_q <= 1'b0;
    end else begin
      if (wr_mask_i) mask_q <= wdata_i & LEGAL;
      if (wr_gate_i) gate_q <= wdata_i[0];
    end
  end

  assign mask_o = mask_q;
  assign gate_o = gate_q;

endmodule

// File: rtl/irq_lowest_find.sv
module irq_lowest_find #(
  parameter int unsigned NSRC  = 27,
  parameter int unsigned IDX_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]  vec_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);

  function automatic logic [IDX_W-1:0] first_set(input logic [NSRC-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  assign idx_o = first_set(vec_i);
  assign any_o = |vec_i;

endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_agg_pkg::*;
#(
  parameter int unsigned     NSRC   = DEF_NSRC,
  parameter int unsigned     DATA_W = DEF_DATA_W,
  parameter int unsigned     ADDR_W = DEF_ADDR_W,
  parameter logic [NSRC-1:0] LEGAL  = DEF_LEGAL
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NSRC-1:0]         evt_i,
  input  logic                    bus_sel_i,
  input  logic                    bus_wr_i,
  input  logic [ADDR_W-1:0]       bus_addr_i,
  input  logic [DATA_W-1:0]       bus_wdata_i,
  output logic [DATA_W-1:0]       bus_rdata_o,
  output logic                    irq_o,
  output logic [$clog2(NSRC)-1:0] irq_idx_o,
  output logic                    pend_any_o
);

  localparam int unsigned IDX_W = $clog2(NSRC);
  localparam int unsigned PAD_W = DATA_W - NSRC;

  reg_hit_t        wr_hit;
  reg_hit_t        rd_hit;
  logic [NSRC-1:0] wdata_src;
  logic [NSRC-1:0] w1c_vec;
  logic [NSRC-1:0] stat_q;
  logic [NSRC-1:0] mask_q;
  logic            gate_q;
  logic [NSRC-1:0] pend;
  logic            unused_wdata_hi;

  assign wdata_src       = bus_wdata_i[NSRC-1:0];
  assign unused_wdata_hi = ^bus_wdata_i[DATA_W-1:NSRC];

  irq_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
    .sel_i    (bus_sel_i),
    .wr_i     (bus_wr_i),
    .addr_i   (bus_addr_i),
    .wr_hit_o (wr_hit),
    .rd_hit_o (rd_hit)
  );

  assign w1c_vec = wr_hit.stat ? wdata_src : '0;

  irq_status_bank #(.NSRC(NSRC), .LEGAL(LEGAL)) u_stat (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt_i  (evt_i),
    .clr_i  (w1c_vec),
    .stat_o (stat_q)
  );

  irq_cfg_regs #(.NSRC(NSRC), .LEGAL(LEGAL)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_mask_i (wr_hit.mask),
    .wr_gate_i (wr_hit.gate),
    .wdata_i   (wdata_src),
    .mask_o    (mask_q),
    .gate_o    (gate_q)
  );

  assign pend = stat_q & mask_q;

  irq_lowest_find #(.NSRC(NSRC), .IDX_W(IDX_W)) u_find (
    .vec_i (pend),
    .idx_o (irq_idx_o),
    .any_o (pend_any_o)
  );

  assign irq_o = gate_q & pend_any_o;

  always_comb begin
    bus_rdata_o = '0;
    unique case (1'b1)
      rd_hit.stat: bus_rdata_o = {{PAD_W{1'b0}}, stat_q};
      rd_hit.mask: bus_rdata_o = {{PAD_W{1'b0}}, mask_q};
      rd_hit.gate: bus_rdata_o = {{(DATA_W-1){1'b0}}, gate_q};
      default:     bus_rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/irq_status_ctrl_chk.sv
module irq_status_ctrl_chk #(
  parameter int unsigned     NSRC  = 27,
  parameter int unsigned     IDX_W = $clog2(NSRC),
  parameter logic [NSRC-1:0] LEGAL = 27'h600_02FF
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NSRC-1:0]  evt_i,
  input logic [NSRC-1:0]  w1c_vec,
  input logic [NSRC-1:0]  stat_q,
  input logic [NSRC-1:0]  mask_q,
  input logic             gate_q,
  input logic [NSRC-1:0]  pend,
  input logic             irq_o,
  input logic [IDX_W-1:0] irq_idx_o,
  input logic             pend_any_o
);

  logic [NSRC-1:0] below_idx;
  assign below_idx = (NSRC'(1) << irq_idx_o) - NSRC'(1);

  AST_STAT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q & ~LEGAL) == '0); // R9

  AST_MASK_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q & ~LEGAL) == '0); // R5

  AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & $past(evt_i & LEGAL)) == $past(evt_i & LEGAL))); // R4

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & $past(w1c_vec & ~evt_i)) == '0)); // R3

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & $past(stat_q & ~w1c_vec)) == $past(stat_q & ~w1c_vec))); // R2

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (gate_q && ((stat_q & mask_q) != '0))); // R7

  AST_IDX_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    pend_any_o |-> pend[irq_idx_o]); // R8

  AST_IDX_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    pend_any_o |-> ((pend & below_idx) == '0)); // R8

  AST_IDX_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_any_o |-> (irq_idx_o == '0)); // R8

endmodule

bind irq_status_ctrl irq_status_ctrl_chk #(
  .NSRC  (NSRC),
  .IDX_W ($clog2(NSRC)),
  .LEGAL (LEGAL)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .evt_i      (evt_i),
  .w1c_vec    (w1c_vec),
  .stat_q     (stat_q),
  .mask_q     (mask_q),
  .gate_q     (gate_q),
  .pend       (pend),
  .irq_o      (irq_o),
  .irq_idx_o  (irq_idx_o),
  .pend_any_o (pend_any_o)
);

// File: tb/sim_irq_status_ctrl.sv
module sim_irq_status_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int N = 27;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] evt_i = '0;
  logic        bus_sel_i = 1'b0;
  logic        bus_wr_i = 1'b0;
  logic [11:0] bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic        irq_o;
  logic [4:0]  irq_idx_o;
  logic        pend_any_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // model state
  logic [N-1:0] m_stat = '0;
  logic [N-1:0] m_mask = '0;
  logic         m_gate = 1'b0;

  irq_status_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
    .bus_sel_i(bus_sel_i), .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
    .irq_o(irq_o), .irq_idx_o(irq_idx_o), .pend_any_o(pend_any_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [N-1:0] legal_bits();
    logic [N-1:0] v;
    v = '0;
    v[25] = 1'b1; v[26] = 1'b1; v[9] = 1'b1;
    for (int i = 0; i < 8; i++) v[i] = 1'b1;
    return v;
  endfunction

  function automatic logic [4:0] exp_idx(input logic [N-1:0] p);
    int k;
    k = 0;
    while (k < N && !p[k]) k++;
    return (k == N) ? 5'd0 : 5'(k);
  endfunction

  function automatic logic [31:0] exp_read(input logic [11:0] a);
    case (a)
      12'h500: return {5'd0, m_stat};
      12'h504: return {5'd0, m_mask};
      12'h508: return {31'd0, m_gate};
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic check_outs();
    logic [N-1:0] p;
    p = m_stat & m_mask;
    chk("R7 irq_o", {31'd0, irq_o}, {31'd0, (m_gate && p != '0)});
    chk("R8 irq_idx_o", {27'd0, irq_idx_o}, {27'd0, exp_idx(p)});
    chk("R8 pend_any_o", {31'd0, pend_any_o}, {31'd0, (p != '0)});
  endtask

  // Drive at the falling edge, check read data, step one edge, check outputs.
  task automatic step(input logic [N-1:0] ev, input logic s, input logic w,
                      input logic [11:0] a, input logic [31:0] d);
    logic [N-1:0] lg;
    lg = legal_bits();
    evt_i = ev; bus_sel_i = s; bus_wr_i = w; bus_addr_i = a; bus_wdata_i = d;
    #1;
    if (s && !w) begin
      case (a)
        12'h500: chk("R2 read status", bus_rdata_o, exp_read(a));
        12'h504: chk("R5 read mask",   bus_rdata_o, exp_read(a));
        12'h508: chk("R6 read gate",   bus_rdata_o, exp_read(a));
        default: chk("R10 read unmapped", bus_rdata_o, 32'd0);
      endcase
    end else begin
      chk("R10 no read", bus_rdata_o, 32'd0);
    end
    @(posedge clk);
    if (s && w && a == 12'h500) m_stat = ((m_stat & ~d[N-1:0]) | ev) & lg;
    else                        m_stat = (m_stat | ev) & lg;
    if (s && w && a == 12'h504) m_mask = d[N-1:0] & lg;
    if (s && w && a == 12'h508) m_gate = d[0];
    @(negedge clk);
    check_outs();
  endtask

  task automatic rd(input logic [11:0] a);
    step('0, 1'b1, 1'b0, a, 32'd0);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    step('0, 1'b1, 1'b1, a, d);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state while held in reset
    chk("R1 irq_o in reset", {31'd0, irq_o}, 32'd0);
    chk("R1 idx in reset", {27'd0, irq_idx_o}, 32'd0);
    rst_n = 1'b1;
    rd(12'h500); rd(12'h504); rd(12'h508);
    chk("R1 irq_o after reset", {31'd0, irq_o}, 32'd0);

    // R5 / R9: mask all ones keeps only implemented positions
    wr(12'h504, 32'hFFFF_FFFF);
    rd(12'h504);
    chk("R5 mask legal only", {5'd0, m_mask}, 32'h0600_02FF);
    // R6: gate write of all ones reads as 1
    wr(12'h508, 32'hFFFF_FFFF);
    rd(12'h508);

    // R2 / R7 / R8: single event
    step(27'h8, 1'b0, 1'b0, 12'h0, 32'd0);
    chk("R8 idx of bit3", {27'd0, irq_idx_o}, 32'd3);
    rd(12'h500);
    // R8: bits 9 and 25 pending, lowest wins
    step((27'h1 << 25) | 27'h200, 1'b0, 1'b0, 12'h0, 32'd0);
    wr(12'h500, 32'h8);
    chk("R8 lowest is 9", {27'd0, irq_idx_o}, 32'd9);
    wr(12'h500, 32'h200);
    chk("R8 next is 25", {27'd0, irq_idx_o}, 32'd25);
    // R4: event and clear in the same cycle on bit 5
    step(27'h20, 1'b1, 1'b1, 12'h500, 32'h20);
    step('0, 1'b1, 1'b1, 12'h500, 32'h0);
    rd(12'h500);
    chk("R4 bit5 kept", {31'd0, bus_rdata_o[5]}, 32'd1);
    // R3: clear with zero bits leaves others
    wr(12'h500, 32'h0200_0000);
    rd(12'h500);
    // R9: events on unimplemented positions
    wr(12'h500, 32'hFFFF_FFFF);
    step(27'h100 | 27'h1000 | (27'h1 << 24), 1'b0, 1'b0, 12'h0, 32'd0);
    rd(12'h500);
    chk("R9 no illegal status", bus_rdata_o, 32'd0);
    // R7: gate off with pending
    step(27'h40, 1'b0, 1'b0, 12'h0, 32'd0);
    wr(12'h508, 32'h0000_0002);
    chk("R7 gate off", {31'd0, irq_o}, 32'd0);
    chk("R8 any without gate", {31'd0, pend_any_o}, 32'd1);
    // R10: unmapped write has no effect
    wr(12'h50C, 32'hFFFF_FFFF);
    wr(12'h000, 32'hFFFF_FFFF);
    rd(12'h50C); rd(12'h500); rd(12'h504); rd(12'h508);

    // random traffic
    for (int t = 0; t < 3000; t++) begin
      logic [N-1:0] ev;
      logic [11:0]  a;
      logic [31:0]  d;
      int           pick;
      ev = N'($urandom & $urandom & $urandom);
      pick = int'($urandom_range(0, 5));
      case (pick)
        0: a = 12'h500;
        1: a = 12'h504;
        2: a = 12'h508;
        3: a = 12'h50C;
        4: a = 12'h500;
        default: a = 12'($urandom);
      endcase
      d = (pick == 4) ? ($urandom & $urandom) : $urandom;
      step(ev, 1'($urandom), 1'($urandom), a, d);
    end

    finish_run();
  end

endmodule